// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of 8-bit general-purpose I/O ports. Every port has an output value register and a direction register. Reading a port's value register returns the synchronised state of its pins. The first three ports can also raise interrupts. Port 0 and port 1 share one combined interrupt output. Port 2 gives each of its lines its own interrupt output. Any further ports, set by a parameter, are plain I/O.

Each interrupt-capable line is set up with two bits. The kind bit chooses between level and edge detection. The polarity bit chooses low/falling or high/rising. A per-line enable gates the line. A level interrupt follows the synchronised pin. An edge interrupt is held pending until software writes a one to that line's acknowledge bit. The status register shows, for each line, the pending or active state after gating by the enable bit. Pins pass through a multi-stage synchroniser before they are read or used for detection. A line driven as an output still feeds its pin value to the detector.

Software accesses the block through a simple register port. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: After reset every line is an input (pin_oe all 0) and pin_out is all 0. Register select 1 is the direction register: a 1 bit drives that line (pin_oe), and the register reads back as written. The address is {port, select[2:0]}.
- R2: Writing register select 0 sets the port's pin_out byte. Reading select 0 returns that port's pin_in byte two clocks after the pins change, whatever the direction.
- R3: With kind (select 2) bit 0, the line is level-sensitive. Polarity (select 3) bit 1 means active high and 0 means active low. Status follows the pin two clocks after a pin change.
- R4: With kind bit 1, a rising edge (polarity 1) or a falling edge (polarity 0) sets a pending bit three clocks after the pin change. The pending bit stays set after the pin returns.
- R5: Writing ones to acknowledge (select 5) clears the pending bits at those positions, and zero bits have no effect. If a new edge arrives in the same cycle as the acknowledge, the pending bit stays set. Acknowledge reads as 0.
- R6: A line whose enable bit (select 4) is 0 shows status 0, and its pending bit is discarded. Edges and polarity changes that happen while the line is disabled produce no interrupt once it is enabled.
- R7: irq_ab is the OR of all status bits of ports 0 and 1. Bit i of irq_line is the status of port 2 line i.
- R8: Reading select 6 returns the port's status byte (enable AND pending or active level).
- R9: Ports numbered 3 and up read 0 on selects 2 to 6, ignore writes to those selects, and never raise an interrupt.
- R10: A line configured as an output still drives interrupt detection from its pin value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | PW+3 | {port index, register select} |
| wdata | input | W | Write data |
| rdata | output | W | Read data for addr (combinational) |
| pin_in | input | NPORT*W | Pin states, port p at bits p*W upward |
| pin_out | output | NPORT*W | Output values for the pins |
| pin_oe | output | NPORT*W | Drive enable per pin |
| irq_ab | output | 1 | Combined interrupt of ports 0 and 1 |
| irq_line | output | W | Per-line interrupts of port 2 |

## Verification
The assertions assume that wr_en is a single-cycle strobe. They also assume that a pin holds each value long enough to pass through the synchroniser and be compared once against its previous sample. Narrower glitches would be lost, and the pending-bit rules are written only for transitions seen in the synchronised domain. The bench changes pins and register inputs only on falling clock edges. It holds every pin level for at least three clocks before the next change, and it toggles only the line under test, so every edge reaches the detector as one clean transition.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int SEL_W = 3;
   localparam int IRQ_PORTS = 3;
   typedef enum logic [SEL_W-1:0] {
      SEL_DATA = 3'd0,
      SEL_DIR  = 3'd1,
      SEL_KIND = 3'd2,
      SEL_POL  = 3'd3,
      SEL_EN   = 3'd4,
      SEL_ACK  = 3'd5,
      SEL_STAT = 3'd6
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage[k] <= '0;
      end else begin
         stage[0] <= d;
         for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] kind,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] en,
   input  logic [W-1:0] ack,
   output logic [W-1:0] stat
);
   logic [W-1:0] prev;
   logic [W-1:0] pend;
   logic [W-1:0] ev;
   logic [W-1:0] active_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   assign active_lvl = ~(lvl ^ pol);
   assign ev         = (lvl ^ prev) & active_lvl;

   for (genvar i = 0; i < W; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pend[i] <= 1'b0;
         else if (!en[i])           pend[i] <= 1'b0;
         else if (kind[i] && ev[i]) pend[i] <= 1'b1;
         else if (ack[i])           pend[i] <= 1'b0;
      end

      assign stat[i] = en[i] & (kind[i] ? pend[i] : active_lvl[i]);

      // R4
      pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend[i] && en[i] && !ack[i]) |=> pend[i]);
      // R6
      pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[i]) |-> $past(en[i] && kind[i]));
      // R5
      ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack[i] && !(kind[i] && ev[i])) |=> !pend[i]);
   end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int W           = 8,
   parameter int NPLAIN      = 1,
   parameter int SYNC_STAGES = 2,
   localparam int NPORT      = IRQ_PORTS + NPLAIN,
   localparam int PW         = $clog2(NPORT),
   localparam int AW         = PW + SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      addr,
   input  logic [W-1:0]       wdata,
   output logic [W-1:0]       rdata,
   input  logic [NPORT*W-1:0] pin_in,
   output logic [NPORT*W-1:0] pin_out,
   output logic [NPORT*W-1:0] pin_oe,
   output logic               irq_ab,
   output logic [W-1:0]       irq_line
);
   if (W < 1) begin : g_bad_w
      $error("gpio_bank: W must be positive");
   end
   if (NPLAIN < 0) begin : g_bad_nplain
      $error("gpio_bank: NPLAIN must not be negative");
   end

   logic [PW-1:0] port_sel;
   reg_sel_e      sel;
   logic          port_ok;
   logic          irq_ok;

   assign port_sel = addr[AW-1:SEL_W];
   assign sel      = reg_sel_e'(addr[SEL_W-1:0]);
   assign port_ok  = int'(port_sel) < NPORT;
   assign irq_ok   = int'(port_sel) < IRQ_PORTS;

   logic [NPORT-1:0][W-1:0]     data_q, dir_q, pin_s;
   logic [IRQ_PORTS-1:0][W-1:0] kind_q, pol_q, en_q, stat_all;
   logic [NPORT*W-1:0]          sync_flat;

   gpio_sync #(.W(NPORT*W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (sync_flat)
   );
   assign pin_s = sync_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         kind_q <= '0;
         pol_q  <= '0;
         en_q   <= '0;
      end else if (wr_en && port_ok) begin
         case (sel)
            SEL_DATA: data_q[port_sel] <= wdata;
            SEL_DIR:  dir_q[port_sel]  <= wdata;
            SEL_KIND: if (irq_ok) kind_q[port_sel[1:0]] <= wdata;
            SEL_POL:  if (irq_ok) pol_q[port_sel[1:0]]  <= wdata;
            SEL_EN:   if (irq_ok) en_q[port_sel[1:0]]   <= wdata;
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < IRQ_PORTS; g++) begin : g_irq
      logic [W-1:0] ack;
      assign ack = (wr_en && int'(port_sel) == g && sel == SEL_ACK) ? wdata : '0;
      gpio_irq_port #(.W(W)) u_port (
         .clk  (clk),
         .rst_n(rst_n),
         .lvl  (pin_s[g]),
         .kind (kind_q[g]),
         .pol  (pol_q[g]),
         .en   (en_q[g]),
         .ack  (ack),
         .stat (stat_all[g])
      );
   end

   always_comb begin
      rdata = '0;
      if (port_ok) begin
         case (sel)
            SEL_DATA: rdata = pin_s[port_sel];
            SEL_DIR:  rdata = dir_q[port_sel];
            SEL_KIND: if (irq_ok) rdata = kind_q[port_sel[1:0]];
            SEL_POL:  if (irq_ok) rdata = pol_q[port_sel[1:0]];
            SEL_EN:   if (irq_ok) rdata = en_q[port_sel[1:0]];
            SEL_STAT: if (irq_ok) rdata = stat_all[port_sel[1:0]];
            default:  rdata = '0;
         endcase
      end
   end

   assign pin_out  = data_q;
   assign pin_oe   = dir_q;
   assign irq_ab   = |{stat_all[0], stat_all[1]};
   assign irq_line = stat_all[2];

   for (genvar g = 0; g < NPORT; g++) begin : g_chk
      // R1
      dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && int'(port_sel) == g && sel == SEL_DIR)
         |=> pin_oe[g*W +: W] == $past(wdata));
   end

   // R7
   irq_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ab |-> (en_q[0] | en_q[1]) != '0);
endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
   localparam int W = 8;
   localparam int NPORT = 4;
   localparam int AW = 5;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               wr_en = 1'b0;
   logic [AW-1:0]      addr = '0;
   logic [W-1:0]       wdata = '0;
   logic [W-1:0]       rdata;
   logic [NPORT*W-1:0] pin_drv = '0;
   logic [NPORT*W-1:0] pin_out, pin_oe;
   logic               irq_ab;
   logic [W-1:0]       irq_line;
   int errs = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpio_bank uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_drv), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_ab(irq_ab), .irq_line(irq_line)
   );

   localparam int S_DATA = 0, S_DIR = 1, S_KIND = 2, S_POL = 3,
                  S_EN = 4, S_ACK = 5, S_STAT = 6;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int p, int s, logic [7:0] d);
      addr = {p[1:0], s[2:0]};
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int p, int s, output logic [7:0] d);
      addr = {p[1:0], s[2:0]};
      #0.5;
      d = rdata;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v;
      step(2);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 reset oe", pin_oe, 0);
      chk("R1 reset out", pin_out, 0);
      chk("R7 reset irq", {irq_ab, irq_line}, 0);

      // R1 R2 direction and data on every port
      for (int p = 0; p < NPORT; p++) begin
         wr(p, S_DIR, 8'hA5 ^ 8'(p));
         chk("R1 oe", pin_oe[p*8 +: 8], 8'hA5 ^ 8'(p));
         rd(p, S_DIR, v);
         chk("R1 dir read", v, 8'hA5 ^ 8'(p));
         wr(p, S_DATA, 8'h3C + 8'(p));
         chk("R2 out", pin_out[p*8 +: 8], 8'h3C + 8'(p));
         pin_drv[p*8 +: 8] = 8'h5A ^ 8'(p * 17);
         step(1);
         rd(p, S_DATA, v);
         chk("R2 sync not yet", v, 8'h00);
         step(1);
         rd(p, S_DATA, v);
         chk("R2 pin read", v, 8'h5A ^ 8'(p * 17));
      end
      pin_drv = '0;
      for (int p = 0; p < NPORT; p++) begin
         wr(p, S_DIR, 8'h00);
         wr(p, S_DATA, 8'h00);
      end
      step(3);

      // R3 R4 R5 R7 R8 sweep of every mode on every interrupt line
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 4; m++) begin
               logic kind, pol;
               logic [7:0] b;
               kind = m[1];
               pol = m[0];
               b = 8'(1 << i);
               wr(p, S_EN, 8'h00);
               wr(p, S_KIND, kind ? b : 8'h00);
               wr(p, S_POL, pol ? b : 8'h00);
               pin_drv[p*8 + i] = ~pol;
               step(4);
               wr(p, S_ACK, 8'hFF);
               wr(p, S_EN, b);
               step(1);
               rd(p, S_STAT, v);
               chk("R8 idle status", v, 0);
               pin_drv[p*8 + i] = pol;
               step(2);
               rd(p, S_STAT, v);
               chk(kind ? "R4 edge not yet" : "R3 level active", v, kind ? 8'h00 : b);
               step(1);
               rd(p, S_STAT, v);
               chk(kind ? "R4 edge pending" : "R3 level held", v, b);
               chk("R7 irq_ab", irq_ab, p < 2);
               chk("R7 irq_line", irq_line, p == 2 ? b : 8'h00);
               pin_drv[p*8 + i] = ~pol;
               step(3);
               rd(p, S_STAT, v);
               chk(kind ? "R4 latched" : "R3 level released", v, kind ? b : 8'h00);
               if (kind) begin
                  wr(p, S_ACK, ~b);
                  rd(p, S_STAT, v);
                  chk("R5 zero bits no effect", v, b);
                  wr(p, S_ACK, b);
                  rd(p, S_STAT, v);
                  chk("R5 ack clears", v, 0);
               end
               wr(p, S_EN, 8'h00);
               pin_drv[p*8 + i] = 1'b0;
               step(3);
            end
         end
      end

      // R5 acknowledge colliding with a new edge, and ack reads 0
      wr(0, S_KIND, 8'h04);
      wr(0, S_POL, 8'h04);
      wr(0, S_ACK, 8'hFF);
      wr(0, S_EN, 8'h04);
      pin_drv[2] = 1'b1;
      step(3);
      pin_drv[2] = 1'b0;
      step(3);
      pin_drv[2] = 1'b1;
      step(2);
      wr(0, S_ACK, 8'h04);
      rd(0, S_STAT, v);
      chk("R5 edge wins over ack", v, 8'h04);
      rd(0, S_ACK, v);
      chk("R5 ack reads zero", v, 0);
      wr(0, S_ACK, 8'h04);
      rd(0, S_STAT, v);
      chk("R5 ack after collision", v, 0);
      wr(0, S_EN, 8'h00);
      pin_drv[2] = 1'b0;
      step(3);

      // R6 edges and reconfiguration while disabled
      wr(2, S_KIND, 8'h08);
      wr(2, S_POL, 8'h08);
      step(3);
      pin_drv[16 + 3] = 1'b1;
      step(4);
      wr(2, S_EN, 8'h08);
      step(2);
      chk("R6 no edge kept while disabled", irq_line, 0);
      wr(2, S_EN, 8'h00);
      wr(2, S_POL, 8'h00);
      wr(2, S_EN, 8'h08);
      step(3);
      chk("R6 polarity change no false edge", irq_line, 0);
      pin_drv[16 + 3] = 1'b0;
      step(3);
      chk("R6 falling edge after enable", irq_line, 8'h08);
      wr(2, S_EN, 8'h00);
      rd(2, S_STAT, v);
      chk("R6 disabled status", v, 0);
      wr(2, S_EN, 8'h08);
      rd(2, S_STAT, v);
      chk("R6 pending discarded", v, 0);
      wr(2, S_EN, 8'h00);

      // R10 output line feeds its detector
      wr(1, S_DIR, 8'h20);
      wr(1, S_KIND, 8'h00);
      wr(1, S_POL, 8'h20);
      wr(1, S_EN, 8'h20);
      wr(1, S_DATA, 8'h20);
      pin_drv[8 + 5] = pin_out[8 + 5];
      step(2);
      chk("R10 output line interrupts", irq_ab, 1);
      wr(1, S_EN, 8'h00);
      wr(1, S_DIR, 8'h00);
      wr(1, S_DATA, 8'h00);
      pin_drv[8 + 5] = 1'b0;
      step(3);

      // R9 plain port has no interrupt registers
      for (int s = S_KIND; s <= S_EN; s++) wr(3, s, 8'hFF);
      for (int s = S_KIND; s <= S_STAT; s++) begin
         rd(3, s, v);
         chk("R9 plain reg reads zero", v, 0);
      end
      pin_drv[31:24] = 8'hFF;
      step(4);
      pin_drv[31:24] = 8'h00;
      step(4);
      chk("R9 plain port no interrupt", {irq_ab, irq_line}, 0);

      done = 1;
      finish_run();
   end
endmodule